// File: doc/BRIEF.md
# Interleaved Two-Port Segmented Converter Decoder

This block feeds the switch array of a current-steering digital-to-analog converter. Two 10-bit word streams arrive on separate ports at half the converter clock rate. Each port has its own capture register, and each register loads on alternate edges of the single fast clock. A select flip-flop toggles on every fast edge and picks one of the registered words. The result is one word stream at the full clock rate.

Each selected word is cut into three tiers. The five upper bits become a 31-line thermometer code of equal-weight coarse switches. The four middle bits become a 15-line thermometer code of fine switches, each worth one sixteenth of a coarse line. The lowest bit drives a single binary-weighted line directly. All 47 lines come from one output register, so the analog switches see every new code on the same edge.

Reset is asynchronous and active-low on assertion. Its release passes through a two-stage synchronizer, so the datapath leaves reset on a clean clock edge.

Top module: `seg_dac_decoder`

## Requirements
- R1: Port A's capture register loads only on edges where the select flip-flop is 1, and port B's only on edges where it is 0. A port value present on any other edge has no effect on the outputs.
- R2: The select flip-flop toggles on every active edge. On the first active edge after reset it selects port A. Starting from the edge after that, with constant port inputs, the outputs alternate between the port B code and the port A code.
- R3: `coarse_sw` has 31 lines, and the number of lines driven high equals bits 9..5 of the selected word.
- R4: `fine_sw` has 15 lines, and the number of lines driven high equals bits 4..1 of the selected word.
- R5: `lsb_sw` equals bit 0 of the selected word.
- R6: Both thermometer codes fill from index 0 upward: for a segment value k, lines 0 to k-1 are high and all others are low.
- R7: A value applied to both ports before rising edge E appears on all 47 output lines after edge E+1, and not after edge E. All lines change on the same edge.
- R8: While `rst_n` is low, all outputs are zero and the select points to port A. After `rst_n` rises, the first two rising edges are still held in reset, and the third rising edge is the first active edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast converter update clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized internally |
| port_a_word | input | 10 | Word stream for the first half of each port period |
| port_b_word | input | 10 | Word stream for the second half of each port period |
| coarse_sw | output | 31 | Thermometer switch lines for the upper five bits |
| fine_sw | output | 15 | Thermometer switch lines for the middle four bits |
| lsb_sw | output | 1 | Direct switch line for the lowest bit |

## Verification
Three things land in the same cycle: one port's capture register loads a new word, the output register decodes the other port's word, and the select flips. Random words on both ports that change on every fast edge make these overlap all the time. The behavioural model then decides, edge by edge, which port value must reach the outputs and which must be ignored. A directed step applied to both ports at once confirms the two-edge latency whichever phase the select is in. Boundary words (all zeros, all ones, single-tier carries) confirm that the three tiers keep their alignment.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;
  localparam int unsigned WORD_W_DEF   = 10;
  localparam int unsigned COARSE_W_DEF = 5;
  localparam int unsigned FINE_W_DEF   = 4;
  localparam int unsigned NUM_PORTS    = 2;
  localparam int unsigned SYNC_STAGES  = 2;

  typedef enum logic {
    PICK_A = 1'b0,
    PICK_B = 1'b1
  } port_pick_e;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int unsigned STAGES = dac_seg_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/dac_port_capture.sv
module dac_port_capture #(
  parameter int unsigned W = dac_seg_pkg::WORD_W_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/dac_therm_decoder.sv
module dac_therm_decoder #(
  parameter int unsigned IN_W  = 5,
  localparam int unsigned LINES = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  code,
  output logic [LINES-1:0] lines
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_comb begin
      lines[i] = (int'(code) > i);
    end
  end
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder #(
  parameter int unsigned WORD_W   = dac_seg_pkg::WORD_W_DEF,
  parameter int unsigned COARSE_W = dac_seg_pkg::COARSE_W_DEF,
  parameter int unsigned FINE_W   = dac_seg_pkg::FINE_W_DEF,
  localparam int unsigned COARSE_N = (1 << COARSE_W) - 1,
  localparam int unsigned FINE_N   = (1 << FINE_W) - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   port_a_word,
  input  logic [WORD_W-1:0]   port_b_word,
  output logic [COARSE_N-1:0] coarse_sw,
  output logic [FINE_N-1:0]   fine_sw,
  output logic                lsb_sw
);
  import dac_seg_pkg::*;

  localparam int unsigned FINE_LO   = WORD_W - COARSE_W - FINE_W;
  localparam int unsigned COARSE_LO = FINE_LO + FINE_W;

  logic              rst_int_n;
  port_pick_e        sel_q;
  port_pick_e        sel_d;
  logic [WORD_W-1:0] port_in [NUM_PORTS];
  logic [WORD_W-1:0] words_q [NUM_PORTS];
  logic [WORD_W-1:0] sel_word;
  logic [COARSE_N-1:0] coarse_d;
  logic [FINE_N-1:0]   fine_d;
  logic                lsb_d;

  dac_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  assign port_in[0] = port_a_word;
  assign port_in[1] = port_b_word;

  // Each port loads on the edge just before the select turns to it.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic load_en;
    assign load_en = (sel_q != port_pick_e'(p));
    dac_port_capture #(.W(WORD_W)) u_cap (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .load_en (load_en),
      .d       (port_in[p]),
      .q       (words_q[p])
    );
  end

  always_comb begin
    sel_d = (sel_q == PICK_A) ? PICK_B : PICK_A;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_q <= PICK_A;
    end else begin
      sel_q <= sel_d;
    end
  end

  always_comb begin
    sel_word = (sel_q == PICK_B) ? words_q[1] : words_q[0];
  end

  dac_therm_decoder #(.IN_W(COARSE_W)) u_coarse_dec (
    .code  (sel_word[WORD_W-1:COARSE_LO]),
    .lines (coarse_d)
  );

  dac_therm_decoder #(.IN_W(FINE_W)) u_fine_dec (
    .code  (sel_word[COARSE_LO-1:FINE_LO]),
    .lines (fine_d)
  );

  assign lsb_d = sel_word[0];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      coarse_sw <= '0;
      fine_sw   <= '0;
      lsb_sw    <= 1'b0;
    end else begin
      coarse_sw <= coarse_d;
      fine_sw   <= fine_d;
      lsb_sw    <= lsb_d;
    end
  end
endmodule

// File: rtl/seg_dac_decoder_chk.sv
module seg_dac_decoder_chk #(
  parameter int unsigned WORD_W   = 10,
  parameter int unsigned COARSE_W = 5,
  parameter int unsigned FINE_W   = 4,
  localparam int unsigned COARSE_N = (1 << COARSE_W) - 1,
  localparam int unsigned FINE_N   = (1 << FINE_W) - 1,
  localparam int unsigned FINE_LO   = WORD_W - COARSE_W - FINE_W,
  localparam int unsigned COARSE_LO = FINE_LO + FINE_W
) (
  input logic                clk,
  input logic                rst_int_n,
  input logic                sel_q,
  input logic [WORD_W-1:0]   word_a_q,
  input logic [WORD_W-1:0]   word_b_q,
  input logic [COARSE_N-1:0] coarse_sw,
  input logic [FINE_N-1:0]   fine_sw,
  input logic                lsb_sw
);
  logic [WORD_W-1:0] picked;
  int unsigned       want_coarse;
  int unsigned       want_fine;

  always_comb begin
    picked      = sel_q ? word_b_q : word_a_q;
    want_coarse = int'(picked[WORD_W-1:COARSE_LO]);
    want_fine   = int'(picked[COARSE_LO-1:FINE_LO]);
  end

  p_hold_a_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sel_q |=> $stable(word_a_q));

  p_hold_b_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    sel_q |=> $stable(word_b_q));

  p_sel_toggle_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(rst_int_n) |-> (sel_q != $past(sel_q)));

  p_coarse_count_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> ($countones(coarse_sw) == $past(want_coarse)));

  p_fine_count_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> ($countones(fine_sw) == $past(want_fine)));

  p_lsb_line_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (lsb_sw == $past(picked[0])));

  p_therm_fill_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (((coarse_sw + 1'b1) & coarse_sw) == '0) && (((fine_sw + 1'b1) & fine_sw) == '0));

  always @(posedge clk) begin
    if (rst_int_n === 1'b0) begin
      p_reset_zero_r8: assert (coarse_sw == '0 && fine_sw == '0 && !lsb_sw && !sel_q);
    end
  end
endmodule

bind seg_dac_decoder seg_dac_decoder_chk #(
  .WORD_W   (WORD_W),
  .COARSE_W (COARSE_W),
  .FINE_W   (FINE_W)
) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .sel_q     (sel_q),
  .word_a_q  (words_q[0]),
  .word_b_q  (words_q[1]),
  .coarse_sw (coarse_sw),
  .fine_sw   (fine_sw),
  .lsb_sw    (lsb_sw)
);

// File: tb/seg_dac_decoder_tb_top.sv
`timescale 1ns/1ps
module seg_dac_decoder_tb_top;
  localparam int W  = 10;
  localparam int CN = 31;
  localparam int FN = 15;

  logic          clk;
  logic          rst_n;
  logic [W-1:0]  pa;
  logic [W-1:0]  pb;
  logic [CN-1:0] coarse_sw;
  logic [FN-1:0] fine_sw;
  logic          lsb_sw;

  int checks;
  int failures;
  bit cmp_en;
  bit done;

  seg_dac_decoder dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_a_word (pa),
    .port_b_word (pb),
    .coarse_sw   (coarse_sw),
    .fine_sw     (fine_sw),
    .lsb_sw      (lsb_sw)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural model: held reset count, select phase, two held words, output word.
  int m_sync, m_sel, m_a, m_b, m_out;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 0; m_sel = 0; m_a = 0; m_b = 0; m_out = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      int nxt;
      nxt = (m_sel != 0) ? m_b : m_a;
      if (m_sel != 0) m_a = int'(pa);
      else            m_b = int'(pb);
      m_out = nxt;
      m_sel = 1 - m_sel;
    end
  end

  function automatic logic [CN-1:0] therm_c(int v);
    logic [CN-1:0] r;
    r = '0;
    for (int i = 0; i < CN; i++) if (i < v) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [FN-1:0] therm_f(int v);
    logic [FN-1:0] r;
    r = '0;
    for (int i = 0; i < FN; i++) if (i < v) r[i] = 1'b1;
    return r;
  endfunction

  task automatic expect_word(int word, string tag);
    logic [CN-1:0] ec;
    logic [FN-1:0] ef;
    logic          el;
    ec = therm_c((word >> 5) & 31);
    ef = therm_f((word >> 1) & 15);
    el = word[0];
    checks++;
    if (coarse_sw !== ec) begin
      failures++;
      $display("FAIL %s R3 coarse actual=%h expected=%h", tag, coarse_sw, ec);
    end
    checks++;
    if (fine_sw !== ef) begin
      failures++;
      $display("FAIL %s R4 fine actual=%h expected=%h", tag, fine_sw, ef);
    end
    checks++;
    if (lsb_sw !== el) begin
      failures++;
      $display("FAIL %s R5 lsb actual=%b expected=%b", tag, lsb_sw, el);
    end
  endtask

  // Shape check: a filled-from-zero code plus one has no bit in common with itself.
  task automatic check_shape();
    checks++;
    if ((((coarse_sw + 1'b1) & coarse_sw) != '0) || (((fine_sw + 1'b1) & fine_sw) != '0)) begin
      failures++;
      $display("FAIL R6 fill order actual=%h/%h expected=contiguous from line 0", coarse_sw, fine_sw);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      expect_word(m_out, "R1 model");
      check_shape();
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R2 stream did not complete actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    int step_v;
    checks = 0; failures = 0; cmp_en = 0; done = 0;
    rst_n = 1'b0;
    pa = 10'h2A5;
    pb = 10'h15A;
    repeat (4) @(negedge clk);
    expect_word(0, "R8 in reset");
    rst_n = 1'b1;
    @(negedge clk); expect_word(0, "R8 held edge1");
    @(negedge clk); expect_word(0, "R8 held edge2");
    @(negedge clk); expect_word(0, "R2 first active edge picks A reg (zero)");
    @(negedge clk); expect_word(10'h15A, "R2 port B next");
    @(negedge clk); expect_word(10'h2A5, "R2 port A next");
    @(negedge clk); expect_word(10'h15A, "R2 alternate B");
    cmp_en = 1;

    for (int i = 0; i < 400; i++) begin
      pa = W'($urandom);
      pb = W'($urandom);
      @(negedge clk);
    end

    foreach (step_v_list[k]) begin
      pa = step_v_list[k];
      pb = step_v_list[(k + 3) % 8];
      repeat (3) @(negedge clk);
    end

    // Step on both ports: old code after one edge, new code after two (R7).
    pa = '0; pb = '0;
    repeat (4) @(negedge clk);
    for (int ph = 0; ph < 2; ph++) begin
      step_v = (ph == 0) ? 10'h3FF : 10'h1E1;
      pa = W'(step_v); pb = W'(step_v);
      @(negedge clk); expect_word((ph == 0) ? 0 : 10'h3FF, "R7 one edge");
      @(negedge clk); expect_word(step_v, "R7 two edges");
      @(negedge clk);
    end

    // Mid-run reset clears outputs at once (R8).
    pa = 10'h3FF; pb = 10'h3FF;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    expect_word(0, "R8 async clear");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 100; i++) begin
      pa = W'($urandom);
      pb = W'($urandom);
      @(negedge clk);
    end

    done = 1;
    finish_run();
  end

  logic [W-1:0] step_v_list [8] = '{10'h000, 10'h3FF, 10'h020, 10'h01F,
                                    10'h3E0, 10'h001, 10'h01E, 10'h200};
endmodule